// File: doc/BRIEF.md
# Dynamic predication mode controller

This block sits in the fetch front end and decides when the machine leaves single-path fetch and starts fetching both sides of a hard-to-predict branch under a predicate. It looks at each decoded branch: the 2-bit type field the compiler attached, the relative offset to the point where the two sides rejoin, the branch PC and a low-confidence flag from the confidence estimator. When it enters the mode it latches the rejoin (merge) address. It pulses a fork strobe that copies the rename table, return stack and global history, and it claims a predicate register id from a pool of 32.

While the mode is active, the controller steers fetch between the two paths one cycle at a time. It watches the fetch PC of the selected path for the merge address. It leaves the mode when both paths have merged, or when the diverge branch resolves. Two optional exit policies, chosen by parameters, are layered on top. A budget policy abandons the mode once too many instructions have been fetched in it. A yield policy hands the mode over to a younger low-confidence diverge branch seen on the predicted path. A resolution that shows the predicted path was wrong raises a flush; that strobe also tells the rename, return stack and history logic to restore the forked copy.

Top module: `dpred_ctrl`

## Requirements
- R1: After reset, mode_o, fork_o, pid_alloc_o, path_sel_o, exit_o and flush_o are 0, and all 32 predicate ids are free, so the first allocation returns id 0.
- R2: The mode is entered only for a valid branch whose type is 2'b10 (forward diverge) or 2'b11 (loop diverge) and whose low-confidence flag is 1. Types 2'b00 (normal) and 2'b01, and high-confidence branches, leave the mode off.
- R3: On entry, in the cycle after the branch: mode_o is 1, fork_o and pid_alloc_o pulse for one cycle, and cfm_o equals the branch PC plus the zero-extended offset, modulo 2^PC_W.
- R4: In the first mode cycle path_sel_o is 0, and it toggles every cycle after that. Once one path has reached the merge address, path_sel_o stays on the other path. Outside the mode it is 0.
- R5: A path reaches the merge address when fetch_valid_i is 1 and fetch_pc_i equals cfm_o in a cycle where that path is selected. When both paths have reached it, exit_o pulses in the next cycle with cause 0 and mode_o drops.
- R6: When res_valid_i is 1 in the mode, the mode ends in the next cycle. The exit cause is 1 when res_mispred_i is 0. It is 2 when res_mispred_i is 1, and flush_o pulses with it. Resolution takes priority over all other exits.
- R7: With the budget policy on, the mode ends with cause 3 in the cycle after the running sum of fetch_cnt_i over fetch cycles in the mode, including the current cycle, exceeds LIMIT (default 64). With the policy off, this sum has no effect.
- R8: With the yield policy on, a low-confidence diverge branch on the predicted path (br_path_i = 0) in the mode, with an id free, gives exit_o with cause 4. In the same cycle the mode is re-entered as in R3, with a fresh merge address, id and path state. With the policy off, the branch is ignored: no exit, and cfm_o is unchanged. Yield ranks below resolution and above budget and merge.
- R9: Ids are granted lowest-free-first and returned by pid_rel_i with pid_rel_id_i. With no id free, a low-confidence diverge branch does not start the mode.
- R10: res_valid_i outside the mode, and diverge branches on the alternate path (br_path_i = 1) in the mode, cause no exit and no flush.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| br_valid_i | input | 1 | Decoded branch present this cycle |
| br_type_i | input | 2 | Branch type: 00 normal, 10 forward diverge, 11 loop diverge |
| br_pc_i | input | PC_W | Branch PC |
| br_cfm_off_i | input | OFF_W | Unsigned offset from branch PC to merge point |
| br_lowconf_i | input | 1 | Confidence estimator flags the branch as low confidence |
| br_path_i | input | 1 | Path the branch was fetched on (0 predicted, 1 alternate) |
| fetch_valid_i | input | 1 | A fetch block was taken from the selected path |
| fetch_pc_i | input | PC_W | PC of that fetch block |
| fetch_cnt_i | input | FCNT_W | Instructions in that fetch block |
| res_valid_i | input | 1 | The active diverge branch resolved |
| res_mispred_i | input | 1 | The resolved diverge branch was mispredicted |
| pid_rel_i | input | 1 | Return a predicate id to the pool |
| pid_rel_id_i | input | ID_W | Id being returned |
| mode_o | output | 1 | Dual-path predicated fetch active |
| cfm_o | output | PC_W | Merge-point register |
| fork_o | output | 1 | Fork strobe for rename table, return stack and global history |
| pid_alloc_o | output | 1 | Predicate id allocated |
| pid_o | output | ID_W | Allocated predicate id |
| path_sel_o | output | 1 | Path to fetch this cycle |
| exit_o | output | 1 | Mode exit strobe |
| exit_cause_o | output | 3 | 0 merge, 1 resolved correct, 2 resolved wrong, 3 budget, 4 yield |
| flush_o | output | 1 | Flush younger work and restore the forked copy |

## Verification
Wrong merge-done flags show at path_sel_o: the path that has merged keeps being picked in alternate cycles, and exit_o with cause 0 comes late or not at all. An off-by-one in the budget sum moves the cause-3 exit by one fetch cycle. A wrong pool mask grants a busy id, or none, at the next entry. A priority mistake shows as the wrong exit_cause_o, or a missing flush_o, in the cycle right after a collision of resolution, yield, budget and merge events.

// File: rtl/dpred_pkg.sv
package dpred_pkg;
  localparam logic [1:0] BR_NORMAL   = 2'b00;
  localparam logic [1:0] BR_DIV_FWD  = 2'b10;
  localparam logic [1:0] BR_DIV_LOOP = 2'b11;

  typedef enum logic [2:0] {
    EX_MERGE    = 3'd0,
    EX_RESOLVED = 3'd1,
    EX_FLUSH    = 3'd2,
    EX_BUDGET   = 3'd3,
    EX_YIELD    = 3'd4
  } exit_cause_e;
endpackage

// File: rtl/dpred_pid_pool.sv
module dpred_pid_pool #(
  parameter int N_IDS = 32,
  localparam int ID_W = $clog2(N_IDS)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            alloc_i,
  input  logic            rel_i,
  input  logic [ID_W-1:0] rel_id_i,
  output logic            any_free_o,
  output logic [ID_W-1:0] grant_o
);
  logic [N_IDS-1:0] free_q, free_d;
  logic             found;

  always_comb begin
    grant_o = '0;
    found   = 1'b0;
    for (int i = 0; i < N_IDS; i++) begin
      if (free_q[i] && !found) begin
        grant_o = ID_W'(i);
        found   = 1'b1;
      end
    end
  end

  assign any_free_o = |free_q;

  always_comb begin
    free_d = free_q;
    if (rel_i) free_d[rel_id_i] = 1'b1;
    if (alloc_i) free_d[grant_o] = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) free_q <= '1;
    else         free_q <= free_d;
  end

  // R9
  alloc_when_free_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alloc_i |-> any_free_o);

  // R9
  granted_taken_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (alloc_i && !(rel_i && rel_id_i == grant_o)) |=> !free_q[$past(grant_o)]);
endmodule

// File: rtl/dpred_budget.sv
module dpred_budget #(
  parameter int LIMIT  = 64,
  parameter int AMT_W  = 4,
  localparam int SUM_W = $clog2(LIMIT + 1) + AMT_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             add_i,
  input  logic [AMT_W-1:0] amt_i,
  output logic             over_o
);
  logic [SUM_W-1:0] cnt_q, sum;

  assign sum    = cnt_q + SUM_W'(amt_i);
  assign over_o = sum > SUM_W'(LIMIT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= '0;
    else if (clr_i) cnt_q <= '0;
    else if (add_i) cnt_q <= sum;
  end

  // R7
  budget_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= SUM_W'(LIMIT));
endmodule

// File: rtl/dpred_path_rr.sv
module dpred_path_rr (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic active_i,
  input  logic hit_i,
  output logic sel_o,
  output logic both_o
);
  logic       sel_q;
  logic [1:0] done_q, done_d;

  always_comb begin
    done_d = done_q;
    if (hit_i) done_d[sel_q] = 1'b1;
  end

  assign both_o = active_i & (&done_d);
  assign sel_o  = sel_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_q  <= 1'b0;
      done_q <= '0;
    end else if (clr_i) begin
      sel_q  <= 1'b0;
      done_q <= '0;
    end else if (active_i) begin
      done_q <= done_d;
      if (done_d[0])      sel_q <= 1'b1;
      else if (done_d[1]) sel_q <= 1'b0;
      else                sel_q <= ~sel_q;
    end
  end

  // R4
  rr_toggle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_i && !clr_i && !hit_i && done_q == 2'b00) |=> sel_o != $past(sel_o));

  // R4
  rr_stick_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_i && !clr_i && done_q[0]) |=> sel_o);
endmodule

// File: rtl/dpred_ctrl.sv
module dpred_ctrl
  import dpred_pkg::*;
#(
  parameter int PC_W       = 32,
  parameter int OFF_W      = 16,
  parameter int FCNT_W     = 4,
  parameter int N_IDS      = 32,
  parameter int LIMIT      = 64,
  parameter bit USE_BUDGET = 1'b1,
  parameter bit USE_YIELD  = 1'b1,
  localparam int ID_W      = $clog2(N_IDS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              br_valid_i,
  input  logic [1:0]        br_type_i,
  input  logic [PC_W-1:0]   br_pc_i,
  input  logic [OFF_W-1:0]  br_cfm_off_i,
  input  logic              br_lowconf_i,
  input  logic              br_path_i,
  input  logic              fetch_valid_i,
  input  logic [PC_W-1:0]   fetch_pc_i,
  input  logic [FCNT_W-1:0] fetch_cnt_i,
  input  logic              res_valid_i,
  input  logic              res_mispred_i,
  input  logic              pid_rel_i,
  input  logic [ID_W-1:0]   pid_rel_id_i,
  output logic              mode_o,
  output logic [PC_W-1:0]   cfm_o,
  output logic              fork_o,
  output logic              pid_alloc_o,
  output logic [ID_W-1:0]   pid_o,
  output logic              path_sel_o,
  output logic              exit_o,
  output logic [2:0]        exit_cause_o,
  output logic              flush_o
);
  logic            mode_q, fork_q, alloc_q, exit_q, flush_q;
  logic [PC_W-1:0] cfm_q;
  logic [ID_W-1:0] pid_q, grant;
  exit_cause_e     cause_q, cause_d;
  logic            any_free, over, both, sel;
  logic            diverge, res_exit, yield, enter, start;
  logic            over_exit, merge_exit, active, hit, exiting;

  assign diverge = br_valid_i & br_lowconf_i &
                   ((br_type_i == BR_DIV_FWD) | (br_type_i == BR_DIV_LOOP));
  assign res_exit   = mode_q & res_valid_i;
  assign yield      = USE_YIELD & mode_q & ~res_valid_i & diverge & ~br_path_i & any_free;
  assign enter      = ~mode_q & diverge & any_free;
  assign start      = enter | yield;
  assign over_exit  = mode_q & ~res_valid_i & ~yield & fetch_valid_i & over;
  assign active     = mode_q & ~res_valid_i & ~yield & ~over_exit;
  assign hit        = active & fetch_valid_i & (fetch_pc_i == cfm_q);
  assign merge_exit = both;
  assign exiting    = res_exit | over_exit | merge_exit;

  dpred_pid_pool #(.N_IDS(N_IDS)) u_pool (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .alloc_i    (start),
    .rel_i      (pid_rel_i),
    .rel_id_i   (pid_rel_id_i),
    .any_free_o (any_free),
    .grant_o    (grant)
  );

  generate
    if (USE_BUDGET) begin : g_budget
      dpred_budget #(.LIMIT(LIMIT), .AMT_W(FCNT_W)) u_budget (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .clr_i  (start),
        .add_i  (active & fetch_valid_i),
        .amt_i  (fetch_cnt_i),
        .over_o (over)
      );
    end else begin : g_no_budget
      assign over = 1'b0;
    end
  endgenerate

  dpred_path_rr u_rr (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clr_i    (start | exiting),
    .active_i (active),
    .hit_i    (hit),
    .sel_o    (sel),
    .both_o   (both)
  );

  always_comb begin
    cause_d = EX_MERGE;
    if (res_exit)       cause_d = res_mispred_i ? EX_FLUSH : EX_RESOLVED;
    else if (yield)     cause_d = EX_YIELD;
    else if (over_exit) cause_d = EX_BUDGET;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q  <= 1'b0;
      cfm_q   <= '0;
      pid_q   <= '0;
      fork_q  <= 1'b0;
      alloc_q <= 1'b0;
      exit_q  <= 1'b0;
      flush_q <= 1'b0;
      cause_q <= EX_MERGE;
    end else begin
      fork_q  <= start;
      alloc_q <= start;
      exit_q  <= exiting | yield;
      flush_q <= res_exit & res_mispred_i;
      if (exiting | yield) cause_q <= cause_d;
      if (start) begin
        mode_q <= 1'b1;
        cfm_q  <= br_pc_i + PC_W'(br_cfm_off_i);
        pid_q  <= grant;
      end else if (exiting) begin
        mode_q <= 1'b0;
      end
    end
  end

  assign mode_o       = mode_q;
  assign cfm_o        = cfm_q;
  assign fork_o       = fork_q;
  assign pid_alloc_o  = alloc_q;
  assign pid_o        = pid_q;
  assign path_sel_o   = sel;
  assign exit_o       = exit_q;
  assign exit_cause_o = cause_q;
  assign flush_o      = flush_q;

  // R3
  entry_fork_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mode_o) |-> (fork_o && pid_alloc_o));

  // R8
  fork_in_mode_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fork_o |-> mode_o);

  // R6
  flush_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_o |-> (exit_o && exit_cause_o == EX_FLUSH));

  // R4
  sel_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mode_o |-> !path_sel_o);

  // R5
  exit_drops_mode_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (exit_o && exit_cause_o != EX_YIELD) |-> !mode_o);

  // R10
  res_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mode_o && res_valid_i && !diverge) |=> (!exit_o && !flush_o));
endmodule

// File: tb/sim_dpred_ctrl.sv
module sim_dpred_ctrl;
  localparam int LIM = 64;
  localparam int NID = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic        bv, blc, bpath, fv, rv, rmis, rel;
  logic [1:0]  bt;
  logic [31:0] bpc, fpc;
  logic [15:0] boff;
  logic [3:0]  fcnt;
  logic [4:0]  relid;

  logic        mode_w [2], fork_w [2], alloc_w [2], sel_w [2], exit_w [2], flush_w [2];
  logic [31:0] cfm_w [2];
  logic [4:0]  pid_w [2];
  logic [2:0]  cause_w [2];

  dpred_ctrl u0 (
    .clk_i(clk), .rst_ni(rst_n), .br_valid_i(bv), .br_type_i(bt), .br_pc_i(bpc),
    .br_cfm_off_i(boff), .br_lowconf_i(blc), .br_path_i(bpath), .fetch_valid_i(fv),
    .fetch_pc_i(fpc), .fetch_cnt_i(fcnt), .res_valid_i(rv), .res_mispred_i(rmis),
    .pid_rel_i(rel), .pid_rel_id_i(relid), .mode_o(mode_w[0]), .cfm_o(cfm_w[0]),
    .fork_o(fork_w[0]), .pid_alloc_o(alloc_w[0]), .pid_o(pid_w[0]), .path_sel_o(sel_w[0]),
    .exit_o(exit_w[0]), .exit_cause_o(cause_w[0]), .flush_o(flush_w[0]));

  dpred_ctrl #(.USE_BUDGET(1'b0), .USE_YIELD(1'b0)) u1 (
    .clk_i(clk), .rst_ni(rst_n), .br_valid_i(bv), .br_type_i(bt), .br_pc_i(bpc),
    .br_cfm_off_i(boff), .br_lowconf_i(blc), .br_path_i(bpath), .fetch_valid_i(fv),
    .fetch_pc_i(fpc), .fetch_cnt_i(fcnt), .res_valid_i(rv), .res_mispred_i(rmis),
    .pid_rel_i(rel), .pid_rel_id_i(relid), .mode_o(mode_w[1]), .cfm_o(cfm_w[1]),
    .fork_o(fork_w[1]), .pid_alloc_o(alloc_w[1]), .pid_o(pid_w[1]), .path_sel_o(sel_w[1]),
    .exit_o(exit_w[1]), .exit_cause_o(cause_w[1]), .flush_o(flush_w[1]));

  int checks = 0;
  int errors = 0;

  // reference state per instance (0: both policies on, 1: both off)
  bit          m_mode [2], m_sel [2], m_fork [2], m_alloc [2], m_exit [2], m_flush [2];
  bit   [1:0]  m_done [2];
  bit   [31:0] m_cfm [2], m_free [2];
  int          m_pid [2], m_cnt [2], m_cause [2];

  task automatic chk(input string tag, input int k, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s u%0d actual=%0h expected=%0h", tag, k, act, exp);
    end
  endtask

  function automatic string cause_tag(input int c);
    case (c)
      0: return "R5 merge";
      1, 2: return "R6 resolve";
      3: return "R7 budget";
      default: return "R8 yield";
    endcase
  endfunction

  task automatic idle();
    bv = 0; bt = 2'b00; bpc = 0; boff = 0; blc = 0; bpath = 0;
    fv = 0; fpc = 32'hffff_ffff; fcnt = 0; rv = 0; rmis = 0; rel = 0; relid = 0;
  endtask

  task automatic model();
    for (int k = 0; k < 2; k++) begin
      bit pol = (k == 0);
      bit div, start;
      int pick = -1;
      for (int i = 0; i < NID; i++) if (m_free[k][i] && pick < 0) pick = i;
      div = bv && blc && (bt == 2'b10 || bt == 2'b11);
      start = 0;
      m_fork[k] = 0; m_alloc[k] = 0; m_exit[k] = 0; m_flush[k] = 0;
      if (!m_mode[k]) start = div && pick >= 0;
      else if (rv) begin
        m_exit[k] = 1; m_cause[k] = rmis ? 2 : 1; m_flush[k] = rmis;
        m_mode[k] = 0; m_sel[k] = 0; m_done[k] = 0;
      end else if (pol && div && !bpath && pick >= 0) begin
        m_exit[k] = 1; m_cause[k] = 4; start = 1;
      end else if (pol && fv && (m_cnt[k] + int'(fcnt)) > LIM) begin
        m_exit[k] = 1; m_cause[k] = 3; m_mode[k] = 0; m_sel[k] = 0; m_done[k] = 0;
      end else begin
        if (fv) begin
          m_cnt[k] += int'(fcnt);
          if (fpc == m_cfm[k]) m_done[k][m_sel[k]] = 1;
        end
        if (m_done[k] == 2'b11) begin
          m_exit[k] = 1; m_cause[k] = 0; m_mode[k] = 0; m_sel[k] = 0; m_done[k] = 0;
        end else if (m_done[k][0]) m_sel[k] = 1;
        else if (m_done[k][1]) m_sel[k] = 0;
        else m_sel[k] = !m_sel[k];
      end
      if (rel) m_free[k][relid] = 1;
      if (start) begin
        m_mode[k] = 1; m_cfm[k] = bpc + {16'h0, boff}; m_pid[k] = pick;
        m_alloc[k] = 1; m_fork[k] = 1; m_sel[k] = 0; m_done[k] = 0; m_cnt[k] = 0;
        m_free[k][pick] = 0;
      end
    end
  endtask

  task automatic compare();
    for (int k = 0; k < 2; k++) begin
      chk("R2 mode", k, mode_w[k], m_mode[k]);
      chk("R3 fork", k, fork_w[k], m_fork[k]);
      chk("R3 alloc", k, alloc_w[k], m_alloc[k]);
      if (m_alloc[k]) chk("R9 pid", k, pid_w[k], m_pid[k]);
      if (m_mode[k]) chk("R3 cfm", k, cfm_w[k], m_cfm[k]);
      chk("R4 sel", k, sel_w[k], m_sel[k]);
      chk(m_exit[k] ? cause_tag(m_cause[k]) : "R10 exit", k, exit_w[k], m_exit[k]);
      if (m_exit[k]) chk(cause_tag(m_cause[k]), k, cause_w[k], m_cause[k]);
      chk("R6 flush", k, flush_w[k], m_flush[k]);
    end
  endtask

  task automatic step();
    model();
    @(posedge clk);
    #1;
    compare();
    @(negedge clk);
    idle();
  endtask

  task automatic enter(input logic [1:0] ty, input logic [31:0] pc, input logic [15:0] off);
    bv = 1; bt = ty; blc = 1; bpc = pc; boff = off;
    step();
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    idle();
    for (int k = 0; k < 2; k++) begin
      m_mode[k] = 0; m_sel[k] = 0; m_done[k] = 0; m_cfm[k] = 0; m_free[k] = '1;
      m_pid[k] = 0; m_cnt[k] = 0; m_cause[k] = 0;
    end
    repeat (3) @(negedge clk);
    // R1 reset state
    for (int k = 0; k < 2; k++) begin
      chk("R1 mode", k, mode_w[k], 0);
      chk("R1 fork", k, fork_w[k], 0);
      chk("R1 alloc", k, alloc_w[k], 0);
      chk("R1 sel", k, sel_w[k], 0);
      chk("R1 exit", k, exit_w[k], 0);
      chk("R1 flush", k, flush_w[k], 0);
    end
    rst_n = 1;
    @(negedge clk);

    // R2: normal, reserved and high-confidence branches do not enter
    enter(2'b00, 32'h100, 16'h20);
    enter(2'b01, 32'h100, 16'h20);
    bv = 1; bt = 2'b10; blc = 0; step();
    chk("R2 no entry", 0, mode_w[0], 0);
    // R10: resolution outside mode
    rv = 1; rmis = 1; step();
    chk("R10 idle flush", 0, flush_w[0], 0);

    // R3: entry with PC wrap, first id 0
    enter(2'b11, 32'hffff_fff0, 16'h0020);
    chk("R3 cfm wrap", 0, cfm_w[0], 32'h0000_0010);
    chk("R1 first id", 0, pid_w[0], 0);
    // R4 toggling, then R5: path0 merges, path1 merges
    step(); step();
    fv = 1; fpc = 32'h10; fcnt = 1; step();     // path 0 hits
    step();
    chk("R4 stick on path1", 0, sel_w[0], 1);
    fv = 1; fpc = 32'h10; fcnt = 1; step();     // path 1 hits
    chk("R5 merge exit", 0, exit_w[0], 1);

    // R10: alternate-path diverge does not yield; R6 mispredict
    enter(2'b10, 32'h200, 16'h40);
    bv = 1; bt = 2'b10; blc = 1; bpath = 1; bpc = 32'h900; step();
    chk("R10 alt path", 0, exit_w[0], 0);
    rv = 1; rmis = 1; step();
    chk("R6 flush", 0, flush_w[0], 1);
    enter(2'b10, 32'h300, 16'h40);
    rv = 1; rmis = 0; bv = 1; bt = 2'b10; blc = 1; bpc = 32'h700; step();
    chk("R6 resolve priority", 0, cause_w[0], 1);

    // R8: yield on u0, ignored on u1
    enter(2'b10, 32'h400, 16'h10);
    bv = 1; bt = 2'b11; blc = 1; bpc = 32'h800; boff = 16'h8; step();
    chk("R8 yield cfm", 0, cfm_w[0], 32'h808);
    chk("R8 ignored cfm", 1, cfm_w[1], 32'h410);

    // R7: budget on u0 only
    rv = 1; step();
    enter(2'b10, 32'h500, 16'h10);
    for (int i = 0; i < 4; i++) begin fv = 1; fpc = 32'h1; fcnt = 15; step(); end
    fv = 1; fpc = 32'h1; fcnt = 5; step();
    chk("R7 budget", 0, cause_w[0], 3);
    chk("R7 no budget", 1, exit_w[1], 0);
    rv = 1; step();

    // R9: exhaust the pool
    for (int i = 0; i < 40; i++) begin
      enter(2'b10, 32'h1000 + i, 16'h4);
      rv = 1; step();
    end
    chk("R9 empty pool", 0, m_free[0], 0);
    enter(2'b10, 32'h2000, 16'h4);
    chk("R9 no entry", 0, mode_w[0], 0);
    rel = 1; relid = 5; step();
    enter(2'b10, 32'h2000, 16'h4);
    chk("R9 reuse", 0, pid_w[0], 5);
    rv = 1; step();

    // constrained random
    for (int n = 0; n < 4000; n++) begin
      bv = ($urandom % 4) == 0;
      bt = 2'($urandom);
      blc = $urandom % 2;
      bpath = ($urandom % 3) == 0;
      bpc = $urandom % 1024;
      boff = 16'($urandom % 64);
      fv = ($urandom % 4) != 0;
      fpc = ($urandom % 2) ? m_cfm[0] : m_cfm[0] + 1;
      fcnt = 4'($urandom);
      rv = ($urandom % 14) == 0;
      rmis = $urandom % 2;
      rel = ($urandom % 3) == 0;
      relid = 5'($urandom);
      step();
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule